// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a byte-wide synchronous serial port with a small register window. Software places a word in a transmit holding register. Once the start conditions are met, the word moves into a shift register and goes out least significant bit first on `sd_out`. At the same time a second shift register collects the bits arriving on `sd_in`. Each bit period is one cycle of a transfer clock. That clock either comes from an internal prescaler and reload divider and appears on `sclk_out`, or is taken from the `sclk_in` pin, which is synchronised into the system clock domain.

A polarity control sets the idle level of the transfer clock. The edge that leaves the idle level is the leading edge and launches a bit. The edge that returns to idle is the trailing edge and samples a bit. A clear-to-send input can hold transmission back. A completed received word is copied into a receive holding register, which raises a receive interrupt. If the previous word has not yet been read, the new word overwrites it and the overrun flag is set instead. The transmit interrupt fires either when a word leaves the holding register or when its last bit has gone out, depending on a control bit.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status reads 0x01 (holding register empty only), `sd_out` is 1, `sclk_out` is high, and `irq_tx`, `irq_rx` and `overrun` are 0.
- R2: A frame has exactly 8 leading and 8 trailing clock edges. `sd_out` presents bit 0 first and moves to the next bit at each leading edge.
- R3: With the internal clock, the transfer clock period is 2·(n+1)·d system cycles. n is the reload register (address 3) and d is 1, 8 or 32 for source field values 0, 1 and 2 (value 3 also selects 32).
- R4: Control bit 3 (polarity) at 0 gives a high idle level and at 1 a low idle level. `sd_out` never changes on a trailing edge, and `sclk_out` rests at the idle level between frames.
- R5: A frame starts only when control bit 0 (transmit enable) is 1 and the holding register is full. When control bit 4 (clear-to-send enable) is 1, `cts_n` must also be low. When bit 4 is 0, `cts_n` is ignored.
- R6: With control bit 2 (external clock) set, a frame starts only while the synchronised `sclk_in` is at the idle level. Bits are then timed by `sclk_in` edges and `sclk_out` holds the idle level.
- R7: A frame receives only if control bit 1 (receive enable) is 1 when it starts. The word sampled from `sd_in` then appears at read address 1. A frame without receive enable leaves the receive status untouched.
- R8: Control bit 5 at 0 gives one `irq_tx` pulse before the first leading edge. At 1 the single pulse comes one cycle after the last trailing edge.
- R9: When a received word lands in an empty receive holding register, `irq_rx` pulses for one cycle and status bit 2 is set.
- R10: When a received word lands in a full receive holding register, the register takes the new word, `overrun` and status bit 3 are set, and `irq_rx` stays low.
- R11: A read of address 1 with `bus_rd` high clears status bits 2 and 3 and the `overrun` output.
- R12: Writing address 0 loads the transmit holding register. Addresses 2 and 3 hold the control and reload registers and read back as written. Reading address 0 gives the status: bit 0 empty, bit 1 busy, bit 2 receive full, bit 3 overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe; clears receive flags at address 1 |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Generated transfer clock |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| cts_n | input | 1 | Clear-to-send, active low |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_rx | output | 1 | Receive interrupt pulse |
| overrun | output | 1 | Overrun flag |

## Verification
The bench loops `sd_out` back to `sd_in` and recovers each word from the line at the trailing edges. A design that shifted most significant bit first, or that launched data on the wrong edge, would return a mirrored or shifted byte, or would show `sd_out` moving on a trailing edge. The bench measures the clock period for several reload and source settings, which exposes an off-by-one in the divider or a wrong prescaler tap. It holds back `cts_n` and the external clock level to show that a frame waits, and it times the end-of-frame transmit interrupt against the last trailing edge. It also sends a second word without reading the first, which catches a design that still raises `irq_rx` on overrun or keeps the old word.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
   typedef enum logic [1:0] {
      SRC_DIV_A  = 2'd0,
      SRC_DIV_B  = 2'd1,
      SRC_DIV_C  = 2'd2,
      SRC_DIV_C2 = 2'd3
   } src_sel_e;

   typedef struct packed {
      src_sel_e src;
      logic     txirq_end;
      logic     cts_en;
      logic     pol;
      logic     ext_clk;
      logic     rx_en;
      logic     tx_en;
   } ctrl_t;

   localparam logic [1:0] A_STAT = 2'd0;
   localparam logic [1:0] A_RXD  = 2'd1;
   localparam logic [1:0] A_CTRL = 2'd2;
   localparam logic [1:0] A_DIV  = 2'd3;
endpackage

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen
   import ssp_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int PRE_A       = 1,
   parameter int PRE_B       = 8,
   parameter int PRE_C       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             ext_sel,
   input  logic             pol,
   input  src_sel_e         src_sel,
   input  logic [DIV_W-1:0] reload,
   input  logic             ext_clk_in,
   output logic             lead,
   output logic             trail,
   output logic             line_out,
   output logic             ext_idle
);
   localparam int PRE_W = $clog2(PRE_C + 1);

   if (PRE_A < 1 || PRE_B < PRE_A || PRE_C < PRE_B) begin : g_bad_pre
      $error("ssp_clkgen: prescale factors must be ascending and >= 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ssp_clkgen: at least two synchroniser stages required");
   end

   logic idle_lvl;
   assign idle_lvl = ~pol;

   // external clock synchroniser chain
   logic sync_q [SYNC_STAGES];
   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[i] <= 1'b1;
            else        sync_q[i] <= ext_clk_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[i] <= 1'b1;
            else        sync_q[i] <= sync_q[i-1];
      end
   end

   logic ext_now, ext_prev, ext_act_now, ext_act_prev;
   assign ext_now = sync_q[SYNC_STAGES-1];
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ext_prev <= 1'b1;
      else        ext_prev <= ext_now;
   assign ext_act_now  = (ext_now  != idle_lvl);
   assign ext_act_prev = (ext_prev != idle_lvl);
   assign ext_idle     = ~ext_act_now;

   // internal prescaler and reload divider
   logic [PRE_W-1:0] pre_cnt, pre_lim;
   logic [DIV_W-1:0] div_cnt;
   logic             phase, pre_tick, tog_int, run_int;

   always_comb begin
      case (src_sel)
         SRC_DIV_A: pre_lim = PRE_W'(PRE_A - 1);
         SRC_DIV_B: pre_lim = PRE_W'(PRE_B - 1);
         default:   pre_lim = PRE_W'(PRE_C - 1);
      endcase
   end

   assign run_int  = active & ~ext_sel;
   assign pre_tick = (pre_cnt == pre_lim);
   assign tog_int  = run_int & pre_tick & (div_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
         phase   <= 1'b0;
      end else if (!run_int) begin
         pre_cnt <= '0;
         div_cnt <= reload;
         phase   <= 1'b0;
      end else begin
         pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
         if (pre_tick) div_cnt <= (div_cnt == '0) ? reload : div_cnt - 1'b1;
         if (tog_int)  phase <= ~phase;
      end
   end

   always_comb begin
      lead  = 1'b0;
      trail = 1'b0;
      if (active) begin
         if (ext_sel) begin
            lead  = ext_act_now & ~ext_act_prev;
            trail = ~ext_act_now & ext_act_prev;
         end else begin
            lead  = tog_int & ~phase;
            trail = tog_int & phase;
         end
      end
   end

   assign line_out = ext_sel ? idle_lvl : (phase ^ idle_lvl);

   AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !ext_sel) |-> (line_out == ~pol)); // R4
   AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ext_sel && lead) |=> !lead); // R6
endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] load_data,
   input  logic              lead,
   input  logic              trail,
   input  logic              ser_in,
   output logic              ser_out,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_word
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   logic [DATA_W-1:0] tx_sr, rx_sr;
   logic [CNT_W-1:0]  bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_sr   <= '0;
         bit_cnt <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         ser_out <= 1'b1;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            tx_sr   <= load_data;
            bit_cnt <= '0;
            busy    <= 1'b1;
         end else if (busy) begin
            if (lead) begin
               ser_out <= tx_sr[0];
               tx_sr   <= tx_sr >> 1;
            end
            if (trail) begin
               rx_sr   <= {ser_in, rx_sr[DATA_W-1:1]};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end
      end
   end

   assign rx_word = rx_sr;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(DATA_W)); // R2
   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R2
endmodule

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
module sync_serial_port
   import ssp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int PRE_A       = 1,
   parameter int PRE_B       = 8,
   parameter int PRE_C       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       sclk_in,
   output logic       sclk_out,
   input  logic       sd_in,
   output logic       sd_out,
   input  logic       cts_n,
   output logic       irq_tx,
   output logic       irq_rx,
   output logic       overrun
);
   localparam int BUS_W = 8;

   if (DATA_W < 2 || DATA_W > BUS_W) begin : g_bad_data
      $error("sync_serial_port: DATA_W must lie in 2..8");
   end
   if (DIV_W < 1 || DIV_W > BUS_W) begin : g_bad_div
      $error("sync_serial_port: DIV_W must lie in 1..8");
   end

   ctrl_t             ctrl;
   logic [DIV_W-1:0]  reload;
   logic [DATA_W-1:0] tx_buf, rx_buf, rx_word;
   logic              tx_empty, rx_full, ovr, rx_on;
   logic              busy, done, lead, trail, ext_idle, start, rd_clr;

   assign start = ctrl.tx_en & ~tx_empty & ~busy
                & (~ctrl.cts_en | ~cts_n)
                & (~ctrl.ext_clk | ext_idle);
   assign rd_clr = bus_rd & (bus_addr == A_RXD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= ctrl_t'(8'h00);
         reload   <= '0;
         tx_buf   <= '0;
         tx_empty <= 1'b1;
         rx_buf   <= '0;
         rx_full  <= 1'b0;
         ovr      <= 1'b0;
         rx_on    <= 1'b0;
         irq_tx   <= 1'b0;
         irq_rx   <= 1'b0;
      end else begin
         irq_rx <= 1'b0;
         irq_tx <= (start & ~ctrl.txirq_end) | (done & ctrl.txirq_end);
         if (start) begin
            tx_empty <= 1'b1;
            rx_on    <= ctrl.rx_en;
         end
         if (bus_wr) begin
            case (bus_addr)
               A_STAT: begin
                  tx_buf   <= bus_wdata[DATA_W-1:0];
                  tx_empty <= 1'b0;
               end
               A_CTRL:  ctrl   <= ctrl_t'(bus_wdata);
               A_DIV:   reload <= bus_wdata[DIV_W-1:0];
               default: ;
            endcase
         end
         if (rd_clr) begin
            rx_full <= 1'b0;
            ovr     <= 1'b0;
         end
         if (done && rx_on) begin
            rx_buf <= rx_word;
            if (rx_full && !rd_clr) begin
               ovr <= 1'b1;
            end else begin
               rx_full <= 1'b1;
               irq_rx  <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      case (bus_addr)
         A_STAT:  bus_rdata = {4'b0000, ovr, rx_full, busy, tx_empty};
         A_RXD:   bus_rdata = BUS_W'(rx_buf);
         A_CTRL:  bus_rdata = ctrl;
         default: bus_rdata = BUS_W'(reload);
      endcase
   end

   assign overrun = ovr;

   ssp_clkgen #(
      .DIV_W(DIV_W), .PRE_A(PRE_A), .PRE_B(PRE_B), .PRE_C(PRE_C),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_clkgen (
      .clk(clk), .rst_n(rst_n), .active(busy), .ext_sel(ctrl.ext_clk),
      .pol(ctrl.pol), .src_sel(ctrl.src), .reload(reload),
      .ext_clk_in(sclk_in), .lead(lead), .trail(trail),
      .line_out(sclk_out), .ext_idle(ext_idle)
   );

   ssp_shifter #(.DATA_W(DATA_W)) u_shifter (
      .clk(clk), .rst_n(rst_n), .start(start), .load_data(tx_buf),
      .lead(lead), .trail(trail), .ser_in(sd_in), .ser_out(sd_out),
      .busy(busy), .done(done), .rx_word(rx_word)
   );

   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(ctrl.tx_en)); // R5
   AST_TXIRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |=> !irq_tx); // R8
   AST_RXFULL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> irq_rx); // R9
   AST_OVR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> !irq_rx); // R10
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !done) |=> (!rx_full && !overrun)); // R11
endmodule

// File: tb/sync_serial_port_bench.sv
`timescale 1ns/1ps
module sync_serial_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00, bus_rdata;
   logic       sclk_in = 1'b1, sclk_out, sd_out, cts_n = 1'b0;
   logic       irq_tx, irq_rx, overrun;
   logic       lb = 1'b1;
   logic       sd_in;
   int         checks = 0, errors = 0;

   // captured line activity
   logic [7:0] cap;
   int n_lead, n_trail, per, n_itx, n_irx, tchg, itx_cyc, last_trail, first_lead;

   assign sd_in = lb ? sd_out : 1'b0;

   always #2 clk = ~clk;

   sync_serial_port u_sync_serial_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk_in(sclk_in), .sclk_out(sclk_out), .sd_in(sd_in), .sd_out(sd_out),
      .cts_n(cts_n), .irq_tx(irq_tx), .irq_rx(irq_rx), .overrun(overrun)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic clr, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = clr;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic watch(input int ncyc, input logic pol);
      logic ps, pd, idle;
      idle = ~pol;
      cap = 8'h00; n_lead = 0; n_trail = 0; per = 0; n_itx = 0; n_irx = 0;
      tchg = 0; itx_cyc = -1; last_trail = -1; first_lead = -1;
      ps = sclk_out; pd = sd_out;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         if (irq_tx) begin n_itx++; itx_cyc = c; end
         if (irq_rx) n_irx++;
         if (sclk_out != ps) begin
            if (sclk_out != idle) begin
               if (n_lead == 0) first_lead = c;
               else if (n_lead == 1) per = c - first_lead;
               n_lead++;
            end else begin
               if (n_trail < 8) cap[n_trail] = sd_out;
               if (sd_out != pd) tchg++;
               n_trail++;
               last_trail = c;
            end
         end
         ps = sclk_out; pd = sd_out;
      end
   endtask

   task automatic t_reset;
      logic [7:0] v;
      rd(2'd0, 1'b0, v);
      chk("R1 status", v, 8'h01);
      chk("R1 sd_out", sd_out, 1);
      chk("R1 sclk_out", sclk_out, 1);
      chk("R1 irqs", {irq_tx, irq_rx, overrun}, 0);
   endtask

   task automatic t_regs;
      logic [7:0] v;
      wr(2'd2, 8'h62);
      wr(2'd3, 8'hA7);
      rd(2'd2, 1'b0, v); chk("R12 ctrl readback", v, 8'h62);
      rd(2'd3, 1'b0, v); chk("R12 reload readback", v, 8'hA7);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_basic;
      logic [7:0] v;
      lb = 1'b1;
      wr(2'd2, 8'h03); wr(2'd3, 8'h01);
      wr(2'd0, 8'hA5);
      watch(80, 1'b0);
      chk("R2 lsb-first word", cap, 8'hA5);
      chk("R2 leading edges", n_lead, 8);
      chk("R2 trailing edges", n_trail, 8);
      chk("R3 period n=1 d=1", per, 4);
      chk("R4 no change on trailing", tchg, 0);
      chk("R8 one tx irq", n_itx, 1);
      chk("R8 tx irq before first lead", (itx_cyc < first_lead) ? 1 : 0, 1);
      chk("R9 one rx irq", n_irx, 1);
      rd(2'd0, 1'b0, v); chk("R12 status after rx", v, 8'h05);
      rd(2'd1, 1'b1, v); chk("R7 received word", v, 8'hA5);
      rd(2'd0, 1'b0, v); chk("R11 status cleared", v, 8'h01);
   endtask

   task automatic t_presc;
      logic [7:0] v;
      wr(2'd2, 8'h41); wr(2'd3, 8'h02);
      wr(2'd0, 8'h5A);
      watch(450, 1'b0);
      chk("R3 period n=2 d=8", per, 48);
      chk("R2 word at d=8", cap, 8'h5A);
      chk("R7 no rx irq when rx off", n_irx, 0);
      rd(2'd0, 1'b0, v); chk("R7 rx status untouched", v, 8'h01);
      wr(2'd2, 8'h81); wr(2'd3, 8'h00);
      wr(2'd0, 8'hC3);
      watch(600, 1'b0);
      chk("R3 period n=0 d=32", per, 64);
      chk("R2 word at d=32", cap, 8'hC3);
   endtask

   task automatic t_pol;
      logic [7:0] v;
      wr(2'd3, 8'h00);
      wr(2'd2, 8'h0B);
      @(negedge clk);
      chk("R4 idle low with pol=1", sclk_out, 0);
      wr(2'd0, 8'h3C);
      watch(60, 1'b1);
      chk("R4 word with pol=1", cap, 8'h3C);
      chk("R4 no change on trailing pol=1", tchg, 0);
      chk("R2 leading edges pol=1", n_lead, 8);
      chk("R4 idle low after frame", sclk_out, 0);
      rd(2'd1, 1'b1, v); chk("R7 rx word pol=1", v, 8'h3C);
   endtask

   task automatic t_cts;
      logic [7:0] v;
      cts_n = 1'b1;
      wr(2'd2, 8'h11);
      wr(2'd0, 8'h96);
      watch(40, 1'b0);
      chk("R5 held by cts", n_lead, 0);
      rd(2'd0, 1'b0, v); chk("R5 buffer still full", v, 8'h00);
      cts_n = 1'b0;
      watch(60, 1'b0);
      chk("R5 runs after cts low", n_lead, 8);
      chk("R5 word after cts", cap, 8'h96);
      cts_n = 1'b1;
      wr(2'd2, 8'h01);
      wr(2'd0, 8'h69);
      watch(60, 1'b0);
      chk("R5 cts ignored when disabled", cap, 8'h69);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h0F);
      watch(40, 1'b0);
      chk("R5 held by tx disable", n_lead, 0);
      wr(2'd2, 8'h01);
      watch(60, 1'b0);
      chk("R5 runs after tx enable", cap, 8'h0F);
      cts_n = 1'b0;
   endtask

   task automatic t_sel1;
      logic [7:0] v;
      wr(2'd2, 8'h23);
      wr(2'd0, 8'h81);
      watch(60, 1'b0);
      chk("R8 one end-of-frame irq", n_itx, 1);
      chk("R8 irq after last trailing", itx_cyc, last_trail + 1);
      chk("R9 rx irq with sel1", n_irx, 1);
      rd(2'd1, 1'b1, v); chk("R7 rx word sel1", v, 8'h81);
   endtask

   task automatic t_ovr;
      logic [7:0] v;
      wr(2'd2, 8'h03);
      wr(2'd0, 8'h11);
      watch(60, 1'b0);
      chk("R9 first rx irq", n_irx, 1);
      wr(2'd0, 8'h22);
      watch(60, 1'b0);
      chk("R10 no rx irq on overrun", n_irx, 0);
      chk("R10 overrun pin", overrun, 1);
      rd(2'd0, 1'b0, v); chk("R10 status overrun", v, 8'h0D);
      rd(2'd1, 1'b1, v); chk("R10 buffer overwritten", v, 8'h22);
      rd(2'd0, 1'b0, v); chk("R11 status cleared", v, 8'h01);
      chk("R11 overrun pin cleared", overrun, 0);
   endtask

   task automatic t_ext;
      logic [7:0] v, got;
      sclk_in = 1'b0;
      wr(2'd2, 8'h07);
      wr(2'd0, 8'hB4);
      repeat (30) @(negedge clk);
      rd(2'd0, 1'b0, v); chk("R6 held while clock active", v, 8'h00);
      chk("R6 sclk_out idle", sclk_out, 1);
      sclk_in = 1'b1;
      repeat (10) @(negedge clk);
      rd(2'd0, 1'b0, v); chk("R6 started at idle", v, 8'h03);
      got = 8'h00;
      for (int i = 0; i < 8; i++) begin
         sclk_in = 1'b0;
         repeat (8) @(negedge clk);
         got[i] = sd_out;
         sclk_in = 1'b1;
         repeat (8) @(negedge clk);
      end
      repeat (10) @(negedge clk);
      chk("R6 word on external clock", got, 8'hB4);
      rd(2'd1, 1'b1, v); chk("R7 rx word external", v, 8'hB4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_regs;
      t_basic;
      t_presc;
      t_pol;
      t_cts;
      t_sel1;
      t_ovr;
      t_ext;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule